// File: doc/BRIEF.md
# Dynamic priority bus arbiter

This block decides which of several bus masters may present an address to the slave side of a shared bus. Each master raises a request line and supplies a two-bit request level. The master count is set by a parameter. A second parameter fixes one of two selection policies when the block is built. In the level-first policy, the master with the highest level wins, and among masters at that level the lowest-numbered one wins. In the least-recently-used policy, the requesting master that was accepted longest ago wins, whatever its level.

Requests are registered on entry. The decision is registered in the next cycle, and in the cycle after that the block presents the address phase as valid, together with a one-hot grant, the encoded winner and the winner's level. The grant stays frozen until the slave accepts the address. It then drops for one cycle before the next decision can be presented.

Top module: `prio_bus_arbiter`

## Requirements
- R1: The level of master i is read from the packed level vector as an unsigned 2-bit value. Bit 2*i carries weight 2 and bit 2*i+1 carries weight 1. Level 0 is the lowest and level 3 the highest. `grant_prio` reports the winner's level.
- R2: With `MODE` set to level-first, a requesting master whose level is strictly greater than that of every other requester wins.
- R3: With `MODE` set to level-first, when several requesters share the highest level, the one with the lowest index wins.
- R4: With `MODE` set to least-recently-used, the requesting master accepted longest ago wins, regardless of level. After reset the ranking is 0, 1, ..., N-1, with master 0 the most favoured.
- R5: In least-recently-used mode, an accepted master moves to the bottom of the ranking. The ranking changes only on a cycle where `addr_valid` and `slv_addr_ack` are both high.
- R6: Requests are sampled at the end of the cycle in which they are driven. The decision is registered one cycle later, and `addr_valid` and the grant outputs show it in the second cycle after the request was driven.
- R7: While `addr_valid` is high and `slv_addr_ack` is low, `addr_valid`, `grant_idx`, `grant_prio` and `mst_grant` stay unchanged.
- R8: In the cycle after `slv_addr_ack` is seen with `addr_valid` high, `addr_valid` is low. If requests are still sampled, a new grant appears in the cycle after that.
- R9: When no master requests, `addr_valid` stays low, `mst_grant` stays zero, and the least-recently-used ranking is left unchanged.
- R10: The reset is synchronous and active low. After reset, `addr_valid` is low and `mst_grant`, `grant_idx` and `grant_prio` are zero.
- R11: While `addr_valid` is high, `mst_grant` has exactly one bit set, at position `grant_idx`. While it is low, `mst_grant` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_req | input | NUM_MST | Request line, one per master |
| mst_prio | input | 2*NUM_MST | Packed request levels; bits 2*i and 2*i+1 belong to master i |
| slv_addr_ack | input | 1 | Slave accepts the presented address |
| addr_valid | output | 1 | Address phase valid, a grant is active |
| mst_grant | output | NUM_MST | One-hot grant |
| grant_idx | output | $clog2(NUM_MST) | Index of the granted master |
| grant_prio | output | 2 | Level of the granted master |

## Verification
A request driven in cycle c shows on `addr_valid` and the grant outputs in cycle c+2. The bench checks that the outputs are still idle at c+1 and correct at c+2, always sampling on the falling edge after the register edge that produces each result. The grant is held through a cycle with no acknowledge and checked again at c+3. The acknowledge given then takes effect at the next edge, so the release is checked at c+4; back-to-back traffic with the acknowledge held high shows the alternating pattern of one cycle valid, one cycle idle. The same stimulus drives one instance built for each policy. The bench computes the level-first winner arithmetically from the packed levels, and keeps its own ranking list for the least-recently-used winner, updated only on accepted grants.

// File: rtl/arb_pkg.sv
// Package: shared types for the bus arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package arb_pkg;

    // Selection policy chosen when the arbiter is built
    typedef enum logic {
        ARB_FIXED = 1'b0,   // highest level wins, lowest index breaks ties
        ARB_LRU   = 1'b1    // least recently accepted requester wins
    } arb_mode_e;

    // Width of one master's request level
    localparam int LVL_W = 2;

endpackage

// File: rtl/arb_req_sample.sv
// Module: arb_req_sample
// Registers the request lines and packed levels once per cycle, so that
// arbitration works on values stable for a whole cycle.
// Assumes a synchronous active-low reset that clears all requests.
module arb_req_sample #(
    parameter int NUM_MST = 4,
    localparam int PW = 2 * NUM_MST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req_in,
    input  logic [PW-1:0]      prio_in,
    output logic [NUM_MST-1:0] req_q,
    output logic [PW-1:0]      prio_q
);

    // Capture stage: holds the requests seen during the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            prio_q <= '0;
        end else begin
            req_q  <= req_in;
            prio_q <= prio_in;
        end
    end

endmodule

// File: rtl/arb_fixed_pick.sv
// Module: arb_fixed_pick
// Combinational level-first selection: the highest level among requesters
// wins, and the lowest index wins among equal levels.
// Assumes levels are packed with bit 2*i weighted 2 and bit 2*i+1 weighted 1.
module arb_fixed_pick #(
    parameter int NUM_MST = 4,
    localparam int PW   = 2 * NUM_MST,
    localparam int IDXW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic [NUM_MST-1:0] req,
    input  logic [PW-1:0]      prio,
    output logic               any,
    output logic [IDXW-1:0]    win_idx
);

    // Scan masters from index 0 upward; only a strictly higher level displaces
    always_comb begin
        logic [1:0] best;
        logic [1:0] lvl;
        logic       found;
        best    = '0;
        found   = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            lvl = {prio[2*i], prio[2*i+1]};
            if (req[i] && (!found || (lvl > best))) begin
                found   = 1'b1;
                best    = lvl;
                win_idx = IDXW'(i);
            end
        end
        any = found;
    end

endmodule

// File: rtl/arb_lru_pick.sv
// Module: arb_lru_pick
// Least-recently-used selection. Keeps a ranking list of master indices;
// position 0 is the most favoured. The requester nearest the head wins.
// An accepted master is moved to the tail.
// Assumes acc_idx names a master whose grant was accepted in this cycle.
module arb_lru_pick #(
    parameter int NUM_MST = 4,
    localparam int IDXW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req,
    input  logic               accept,
    input  logic [IDXW-1:0]    acc_idx,
    output logic               any,
    output logic [IDXW-1:0]    win_idx
);

    logic [IDXW-1:0] order_q [NUM_MST];
    logic [IDXW-1:0] order_d [NUM_MST];

    // Winner: walk from the tail to the head so the head-most requester remains
    always_comb begin
        any     = |req;
        win_idx = '0;
        for (int p = NUM_MST - 1; p >= 0; p--) begin
            if (req[order_q[p]]) win_idx = order_q[p];
        end
    end

    // Next ranking: remove the accepted master and append it at the tail
    always_comb begin
        int k;
        k = 0;
        for (int p = 0; p < NUM_MST; p++) begin
            if (order_q[p] == acc_idx) k = p;
        end
        for (int p = 0; p < NUM_MST; p++) begin
            if (p == NUM_MST - 1)
                order_d[p] = acc_idx;
            else if (p >= k)
                order_d[p] = order_q[(p + 1) % NUM_MST];
            else
                order_d[p] = order_q[p];
        end
    end

    // Ranking register: identity order at reset, updated only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_MST; p++) order_q[p] <= IDXW'(p);
        end else if (accept) begin
            for (int p = 0; p < NUM_MST; p++) order_q[p] <= order_d[p];
        end
    end

endmodule

// File: rtl/prio_bus_arbiter.sv
// Module: prio_bus_arbiter (top)
// Bus arbiter for NUM_MST masters with a build-time policy. Requests are
// registered, the decision is registered a cycle later, and the grant is
// held until the slave acknowledges the address.
// Assumes the slave acknowledges only while addr_valid is high; an
// acknowledge at other times is ignored.
module prio_bus_arbiter
    import arb_pkg::*;
#(
    parameter int        NUM_MST = 4,
    parameter arb_mode_e MODE    = ARB_FIXED,
    localparam int PW   = 2 * NUM_MST,
    localparam int IDXW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] mst_req,
    input  logic [PW-1:0]      mst_prio,
    input  logic               slv_addr_ack,
    output logic               addr_valid,
    output logic [NUM_MST-1:0] mst_grant,
    output logic [IDXW-1:0]    grant_idx,
    output logic [LVL_W-1:0]   grant_prio
);

    logic [NUM_MST-1:0] req_q;
    logic [PW-1:0]      prio_q;
    logic               pick_any;
    logic [IDXW-1:0]    pick_idx;
    logic [LVL_W-1:0]   pick_lvl;
    logic               accept;

    assign accept = addr_valid & slv_addr_ack;

    arb_req_sample #(.NUM_MST(NUM_MST)) u_sample (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (mst_req),
        .prio_in (mst_prio),
        .req_q   (req_q),
        .prio_q  (prio_q)
    );

    generate
        if (MODE == ARB_LRU) begin : g_lru
            arb_lru_pick #(.NUM_MST(NUM_MST)) u_pick (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (req_q),
                .accept  (accept),
                .acc_idx (grant_idx),
                .any     (pick_any),
                .win_idx (pick_idx)
            );
        end else begin : g_fixed
            arb_fixed_pick #(.NUM_MST(NUM_MST)) u_pick (
                .req     (req_q),
                .prio    (prio_q),
                .any     (pick_any),
                .win_idx (pick_idx)
            );
        end
    endgenerate

    // Level of the chosen master, read from the sampled packed levels
    always_comb begin
        pick_lvl = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (pick_idx == IDXW'(i)) pick_lvl = {prio_q[2*i], prio_q[2*i+1]};
        end
    end

    // Grant register: release on acknowledge, else load a new decision when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid <= 1'b0;
            grant_idx  <= '0;
            grant_prio <= '0;
        end else if (addr_valid) begin
            if (slv_addr_ack) addr_valid <= 1'b0;
        end else if (pick_any) begin
            addr_valid <= 1'b1;
            grant_idx  <= pick_idx;
            grant_prio <= pick_lvl;
        end
    end

    // One-hot grant decoded from the held index
    always_comb begin
        mst_grant = '0;
        if (addr_valid) mst_grant[grant_idx] = 1'b1;
    end

endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Protocol and timing properties of the arbiter, observed at its ports.
// Assumes it is bound to prio_bus_arbiter, with the same master count.
module arb_checker #(
    parameter int NUM_MST = 4,
    localparam int PW   = 2 * NUM_MST,
    localparam int IDXW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_MST-1:0] mst_req,
    input logic [PW-1:0]      mst_prio,
    input logic               slv_addr_ack,
    input logic               addr_valid,
    input logic [NUM_MST-1:0] mst_grant,
    input logic [IDXW-1:0]    grant_idx,
    input logic [1:0]         grant_prio
);

    logic [NUM_MST-1:0] req_d1, req_d2;
    logic [PW-1:0]      prio_d1, prio_d2;
    logic [1:0]         lvl_at_idx;

    // Delay line of the master inputs, matching the two-stage latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d1  <= '0;
            req_d2  <= '0;
            prio_d1 <= '0;
            prio_d2 <= '0;
        end else begin
            req_d1  <= mst_req;
            req_d2  <= req_d1;
            prio_d1 <= mst_prio;
            prio_d2 <= prio_d1;
        end
    end

    // Level that the granted master presented when its request was sampled
    always_comb begin
        lvl_at_idx = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (grant_idx == IDXW'(i)) lvl_at_idx = {prio_d2[2*i], prio_d2[2*i+1]};
        end
    end

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!addr_valid && (mst_grant == '0)));

    p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ($onehot(mst_grant) && mst_grant[grant_idx]));

    p_grant_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (mst_grant == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !slv_addr_ack) |=>
            (addr_valid && $stable(grant_idx) && $stable(grant_prio)));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && slv_addr_ack) |=> !addr_valid);

    p_winner_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> req_d2[grant_idx]);

    p_level_reported_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> (grant_prio == lvl_at_idx));

    p_no_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && (req_d1 == '0)) |=> !addr_valid);

endmodule

bind prio_bus_arbiter arb_checker #(.NUM_MST(NUM_MST)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mst_req      (mst_req),
    .mst_prio     (mst_prio),
    .slv_addr_ack (slv_addr_ack),
    .addr_valid   (addr_valid),
    .mst_grant    (mst_grant),
    .grant_idx    (grant_idx),
    .grant_prio   (grant_prio)
);

// File: tb/sim_prio_bus_arbiter.sv
// Bench: sweeps every request pattern against every packed level vector for
// four masters, on one instance per policy, with expected winners computed
// in the bench.
`timescale 1ns/1ps
module sim_prio_bus_arbiter;
    import arb_pkg::*;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [2*N-1:0] prio = '0;
    logic         ack = 1'b0;

    logic         av0, av1;
    logic [N-1:0] gnt0, gnt1;
    logic [1:0]   idx0, idx1;
    logic [1:0]   pr0, pr1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ord [N];

    always #4 clk = ~clk;   // 125 MHz

    prio_bus_arbiter #(.NUM_MST(N), .MODE(ARB_FIXED)) u0 (
        .clk(clk), .rst_n(rst_n), .mst_req(req), .mst_prio(prio),
        .slv_addr_ack(ack), .addr_valid(av0), .mst_grant(gnt0),
        .grant_idx(idx0), .grant_prio(pr0)
    );

    prio_bus_arbiter #(.NUM_MST(N), .MODE(ARB_LRU)) u1 (
        .clk(clk), .rst_n(rst_n), .mst_req(req), .mst_prio(prio),
        .slv_addr_ack(ack), .addr_valid(av1), .mst_grant(gnt1),
        .grant_idx(idx1), .grant_prio(pr1)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl_of(input logic [2*N-1:0] p, input int i);
        return 2 * int'(p[2*i]) + int'(p[2*i+1]);
    endfunction

    // Level-first winner: highest level, lowest index among equals
    function automatic int fixed_win(input logic [N-1:0] r, input logic [2*N-1:0] p);
        int w;
        w = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && (w < 0 || lvl_of(p, i) > lvl_of(p, w))) w = i;
        return w;
    endfunction

    function automatic int count_at(input logic [N-1:0] r, input logic [2*N-1:0] p, input int lv);
        int c;
        c = 0;
        for (int i = 0; i < N; i++)
            if (r[i] && lvl_of(p, i) == lv) c++;
        return c;
    endfunction

    function automatic int rr_win(input logic [N-1:0] r);
        for (int q = 0; q < N; q++)
            if (r[ord[q]]) return ord[q];
        return -1;
    endfunction

    task automatic rr_accept(input int g);
        int k;
        k = 0;
        for (int q = 0; q < N; q++) if (ord[q] == g) k = q;
        for (int q = k; q < N - 1; q++) ord[q] = ord[q + 1];
        ord[N - 1] = g;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One full request/hold/acknowledge round, checked cycle by cycle
    task automatic do_round(input logic [N-1:0] r, input logic [2*N-1:0] p);
        int ef, er, el;
        string t23;
        ef = fixed_win(r, p);
        er = rr_win(r);
        req = r; prio = p; ack = 1'b0;          // cycle c
        @(negedge clk);                          // cycle c+1
        chk(!av0 && !av1, "R6 early", int'(av0) + int'(av1), 0);
        req = '0;
        @(negedge clk);                          // cycle c+2
        if (ef < 0) begin
            chk(!av0 && !av1 && gnt0 == '0 && gnt1 == '0, "R9 idle",
                int'(av0) + int'(av1), 0);
            @(negedge clk);
            chk(!av0 && !av1, "R9 idle later", int'(av0) + int'(av1), 0);
            return;
        end
        el = lvl_of(p, ef);
        t23 = (count_at(r, p, el) > 1) ? "R3 tie" : "R2 level";
        chk(av0 && av1, "R6 valid", int'(av0) + int'(av1), 2);
        chk(int'(idx0) == ef, t23, int'(idx0), ef);
        chk(int'(pr0) == el, "R1 fixed level", int'(pr0), el);
        chk(gnt0 == N'(1 << ef), "R11 onehot", int'(gnt0), 1 << ef);
        chk(int'(idx1) == er, "R4 R5 lru winner", int'(idx1), er);
        chk(int'(pr1) == lvl_of(p, er), "R1 lru level", int'(pr1), lvl_of(p, er));
        @(negedge clk);                          // cycle c+3: no acknowledge yet
        chk(av0 && av1 && int'(idx0) == ef && int'(idx1) == er && int'(pr0) == el,
            "R7 hold", int'(idx1), er);
        ack = 1'b1;
        @(negedge clk);                          // cycle c+4: released
        chk(!av0 && !av1 && gnt0 == '0 && gnt1 == '0, "R8 release",
            int'(av0) + int'(av1), 0);
        ack = 1'b0;
        rr_accept(er);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int q = 0; q < N; q++) ord[q] = q;
        req = 4'hF; prio = 8'hFF; ack = 1'b1;
        repeat (4) @(negedge clk);
        // R10: reset state despite active inputs
        chk(!av0 && !av1, "R10 valid", int'(av0) + int'(av1), 0);
        chk(gnt0 == '0 && gnt1 == '0, "R10 grant", int'(gnt0 | gnt1), 0);
        chk(idx0 == '0 && idx1 == '0 && pr0 == '0 && pr1 == '0, "R10 index level",
            int'(idx0) + int'(idx1) + int'(pr0) + int'(pr1), 0);
        req = '0; prio = '0; ack = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R4: first grant after reset favours master 0 under equal history
        do_round(4'b1011, 8'b00_00_00_11);

        // Full sweep of request patterns against packed level vectors
        for (int r = 0; r < 16; r++)
            for (int p = 0; p < 256; p++)
                do_round(N'(r), 8'(p));

        // R9: idle cycles leave the ranking untouched
        req = '0;
        repeat (10) begin
            @(negedge clk);
            chk(!av0 && !av1, "R9 idle cycle", int'(av0) + int'(av1), 0);
        end
        do_round(4'hF, 8'h00);

        // R8: back-to-back traffic with acknowledge held high
        req = 4'hF; prio = 8'h00; ack = 1'b1;
        @(negedge clk);
        chk(!av0 && !av1, "R6 b2b early", int'(av0) + int'(av1), 0);
        for (int k = 0; k < 6; k++) begin
            int er;
            er = rr_win(4'hF);
            @(negedge clk);
            chk(av0 && av1, "R8 b2b valid", int'(av0) + int'(av1), 2);
            chk(idx0 == 2'd0, "R3 b2b fixed", int'(idx0), 0);
            chk(int'(idx1) == er, "R5 b2b rotate", int'(idx1), er);
            rr_accept(er);
            if (k == 5) req = '0;
            @(negedge clk);
            chk(!av0 && !av1, "R8 b2b gap", int'(av0) + int'(av1), 0);
        end
        ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(!av0 && !av1, "R9 after b2b", int'(av0) + int'(av1), 0);
        finish_run();
    end

endmodule